// File: doc/BRIEF.md
# Reversible Two's-Complement Adder/Subtractor Chain

This block adds or subtracts two n-bit two's-complement operands using only reversible primitives: controlled inverters (a control line copied through and XOR-ed onto a target) and three-line gates that pass the first line, XOR it onto the second and XOR the product of both onto the third. No line is ever created, dropped or fanned out, so each combination of input lines, ancilla lines included, produces its own output combination and the whole mapping is a bijection.

Each bit slice conditionally inverts its Y bit with the mode line, runs a two-gate full adder, and hands a copy of the mode line and its carry on to the next slice. The carry into the lowest slice is made by XOR-ing the mode line onto a zero ancilla, which supplies the extra +1 of a two's-complement subtraction. A second zero ancilla receives a copy of the carry entering the top slice; XOR-ing the final carry onto that copy yields the signed-overflow flag. All garbage lines are brought out as ports so the mapping can be examined as a whole. The block is purely combinational and has no clock or reset.

Top module: `rev_addsub_chain`

## Requirements
- R1: With every ancilla input at 0 and `sub_mode` = 0, `result` equals (`op_x` + `op_y`) modulo 2^WIDTH.
- R2: With every ancilla input at 0 and `sub_mode` = 1, `result` equals (`op_x` - `op_y`) modulo 2^WIDTH.
- R3: With ancillas at 0, `carry_out` is 1 in add mode exactly when `op_x` + `op_y` ≥ 2^WIDTH as unsigned values, and in subtract mode exactly when `op_x` ≥ `op_y` as unsigned values (no borrow).
- R4: With ancillas at 0, `overflow` is 1 exactly when the signed result of the selected operation, operands read as two's complement, lies outside [-2^(WIDTH-1), 2^(WIDTH-1)-1].
- R5: `mode_fwd` always equals `sub_mode` (the copy passed from slice to slice leaves the top slice unchanged).
- R6: `x_copy[i]` always equals `op_x[i]` for every bit i.
- R7: `parity[i]` always equals `op_x[i]` XOR `op_y[i]` XOR `sub_mode` for every bit i.
- R8: For WIDTH = 3, the 12-bit output vector {`overflow`, `carry_out`, `mode_fwd`, `result`, `x_copy`, `parity`} takes a different value for each of the 4096 values of the 12-bit input vector {`anc_ovf`, `anc_cin`, `anc_slice`, `sub_mode`, `op_x`, `op_y`}.
- R9: With `anc_cin` = 1 and other ancillas 0, the carry into bit 0 becomes `sub_mode` XOR 1, so in add mode `result` equals (`op_x` + `op_y` + 1) modulo 2^WIDTH.
- R10: With `anc_ovf` = 1 and other ancillas 0, `overflow` is the inverse of the value R4 gives, while `result` and `carry_out` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_x | input | WIDTH | First operand (minuend in subtract mode) |
| op_y | input | WIDTH | Second operand (subtrahend in subtract mode) |
| sub_mode | input | 1 | 0 selects addition, 1 selects subtraction |
| anc_slice | input | WIDTH | Per-slice ancilla lines, 0 in normal use |
| anc_cin | input | 1 | Ancilla that becomes the bit-0 carry-in, 0 in normal use |
| anc_ovf | input | 1 | Ancilla that receives the top carry-in copy, 0 in normal use |
| result | output | WIDTH | Sum or difference bits |
| carry_out | output | 1 | Carry out of the top slice |
| overflow | output | 1 | Signed overflow flag |
| mode_fwd | output | 1 | Mode copy emerging from the top slice (garbage) |
| x_copy | output | WIDTH | Pass-through copy of op_x per slice (garbage) |
| parity | output | WIDTH | X ⊕ Y ⊕ mode per slice (garbage) |

## Verification
The bench builds two instances: one with WIDTH = 3 and one with WIDTH = 8. The 3-bit instance makes the whole 12-line input space small enough to walk completely, so bijectivity is checked over every ancilla value and every operand pair is compared in both modes against signed and unsigned range arithmetic. The 8-bit instance is driven from a vector table covering the signed limits, wrap-around of unsigned carries, equal operands under subtraction and the effect of forcing each carry-related ancilla high.

// File: rtl/rev_pkg.sv
package rev_pkg;

  // Output lines of one reversible bit slice, in no particular electrical order.
  typedef struct packed {
    logic mode_cp;  // forwarded mode copy
    logic x_cp;     // forwarded X copy
    logic parity;   // X ^ Y ^ mode
    logic sd;       // sum / difference bit
    logic carry;    // carry into the next slice
  } slice_out_t;

  localparam int unsigned MIN_WIDTH = 2;

endpackage

// File: rtl/rev_cnot.sv
// Controlled inverter: control passes through, target is XOR-ed with it.
module rev_cnot (
  input  logic ctl_i,
  input  logic tgt_i,
  output logic ctl_o,
  output logic tgt_o
);
  assign ctl_o = ctl_i;
  assign tgt_o = tgt_i ^ ctl_i;
endmodule

// File: rtl/rev_peres.sv
// Three-line reversible gate: (a, b, c) -> (a, a^b, (a&b)^c).
module rev_peres (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic a_o,
  output logic b_o,
  output logic c_o
);
  assign a_o = a_i;
  assign b_o = a_i ^ b_i;
  assign c_o = (a_i & b_i) ^ c_i;
endmodule

// File: rtl/rev_slice.sv
// One reversible add/subtract bit: conditional invert of Y, then a
// two-gate full adder. Five lines in, five lines out.
module rev_slice
  import rev_pkg::*;
(
  input  logic       mode_i,
  input  logic       x_i,
  input  logic       y_i,
  input  logic       cin_i,
  input  logic       anc_i,
  output slice_out_t out_o
);
  logic y_eff;
  logic half_sum;
  logic gen;

  rev_cnot u_inv (
    .ctl_i (mode_i),
    .tgt_i (y_i),
    .ctl_o (out_o.mode_cp),
    .tgt_o (y_eff)
  );

  rev_peres u_half (
    .a_i (x_i),
    .b_i (y_eff),
    .c_i (anc_i),
    .a_o (out_o.x_cp),
    .b_o (half_sum),
    .c_o (gen)
  );

  rev_peres u_full (
    .a_i (half_sum),
    .b_i (cin_i),
    .c_i (gen),
    .a_o (out_o.parity),
    .b_o (out_o.sd),
    .c_o (out_o.carry)
  );
endmodule

// File: rtl/rev_addsub_chain.sv
module rev_addsub_chain
  import rev_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] op_x,
  input  logic [WIDTH-1:0] op_y,
  input  logic             sub_mode,
  input  logic [WIDTH-1:0] anc_slice,
  input  logic             anc_cin,
  input  logic             anc_ovf,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             overflow,
  output logic             mode_fwd,
  output logic [WIDTH-1:0] x_copy,
  output logic [WIDTH-1:0] parity
);
  localparam int unsigned TOP = WIDTH - 1;

  logic [WIDTH:0]   mode_line;   // mode copy entering slice i
  logic [WIDTH:0]   carry_line;  // carry leaving slice i-1
  logic [WIDTH-1:0] cin_line;    // carry actually entering slice i
  logic             top_cin_cp;  // copy of carry into the top slice
  slice_out_t       slc [WIDTH];

  // Bit-0 carry-in: mode XOR-ed onto the zero ancilla.
  rev_cnot u_lsb_cin (
    .ctl_i (sub_mode),
    .tgt_i (anc_cin),
    .ctl_o (mode_line[0]),
    .tgt_o (carry_line[0])
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == TOP) begin : g_top
      // Copy the top carry-in onto its ancilla before the top slice uses it.
      rev_cnot u_cin_copy (
        .ctl_i (carry_line[i]),
        .tgt_i (anc_ovf),
        .ctl_o (cin_line[i]),
        .tgt_o (top_cin_cp)
      );
    end else begin : g_low
      assign cin_line[i] = carry_line[i];
    end

    rev_slice u_slice (
      .mode_i (mode_line[i]),
      .x_i    (op_x[i]),
      .y_i    (op_y[i]),
      .cin_i  (cin_line[i]),
      .anc_i  (anc_slice[i]),
      .out_o  (slc[i])
    );

    assign mode_line[i+1]  = slc[i].mode_cp;
    assign carry_line[i+1] = slc[i].carry;
    assign result[i]       = slc[i].sd;
    assign x_copy[i]       = slc[i].x_cp;
    assign parity[i]       = slc[i].parity;
  end

  // Overflow: final carry XOR-ed onto the copied top carry-in.
  rev_cnot u_ovf (
    .ctl_i (carry_line[WIDTH]),
    .tgt_i (top_cin_cp),
    .ctl_o (carry_out),
    .tgt_o (overflow)
  );

  assign mode_fwd = mode_line[WIDTH];

  // Checks against plain arithmetic, independent of the gate network.
  logic             anc_clear;
  logic [WIDTH:0]   ref_sum;
  logic [WIDTH:0]   ref_diff;
  logic             ref_sovf;

  always_comb begin
    anc_clear = (anc_slice == '0) && !anc_cin && !anc_ovf;
    ref_sum   = {1'b0, op_x} + {1'b0, op_y};
    ref_diff  = {1'b0, op_x} + {1'b0, ~op_y} + 1'b1;
    if (sub_mode)
      ref_sovf = (op_x[TOP] != op_y[TOP]) && (ref_diff[TOP] != op_x[TOP]);
    else
      ref_sovf = (op_x[TOP] == op_y[TOP]) && (ref_sum[TOP] != op_x[TOP]);

    if (anc_clear && !sub_mode) begin
      a_r1_add_sum: assert (result == ref_sum[WIDTH-1:0])
        else $error("R1 sum mismatch");
      a_r3_add_carry: assert (carry_out == ref_sum[WIDTH])
        else $error("R3 add carry mismatch");
    end
    if (anc_clear && sub_mode) begin
      a_r2_sub_diff: assert (result == ref_diff[WIDTH-1:0])
        else $error("R2 difference mismatch");
      a_r3_sub_carry: assert (carry_out == (op_x >= op_y))
        else $error("R3 borrow mismatch");
    end
    if (anc_clear) begin
      a_r4_signed_ovf: assert (overflow == ref_sovf)
        else $error("R4 overflow mismatch");
    end
    a_r5_mode_copy: assert (mode_fwd == sub_mode)
      else $error("R5 mode copy mismatch");
    a_r6_x_copy: assert (x_copy == op_x)
      else $error("R6 X copy mismatch");
  end

endmodule

// File: tb/rev_addsub_chain_test.sv
module rev_addsub_chain_test;

  localparam int unsigned NS = 3;
  localparam int unsigned NW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;  // 125 MHz

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // Small instance
  logic [NS-1:0] sx, sy, sanc, sres, sxc, spar;
  logic          smode, sacin, saovf, scout, sovf, smf;

  rev_addsub_chain #(.WIDTH(NS)) uut (
    .op_x(sx), .op_y(sy), .sub_mode(smode), .anc_slice(sanc),
    .anc_cin(sacin), .anc_ovf(saovf), .result(sres), .carry_out(scout),
    .overflow(sovf), .mode_fwd(smf), .x_copy(sxc), .parity(spar)
  );

  // Wide instance
  logic [NW-1:0] wx, wy, wanc, wres, wxc, wpar;
  logic          wmode, wacin, waovf, wcout, wovf, wmf;

  rev_addsub_chain #(.WIDTH(NW)) uut_wide (
    .op_x(wx), .op_y(wy), .sub_mode(wmode), .anc_slice(wanc),
    .anc_cin(wacin), .anc_ovf(waovf), .result(wres), .carry_out(wcout),
    .overflow(wovf), .mode_fwd(wmf), .x_copy(wxc), .parity(wpar)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // {mode, x, y, result, carry, ovf}
  localparam int NVEC = 9;
  localparam logic [26:0] VEC [NVEC] = '{
    {1'b0, 8'h05, 8'h03, 8'h08, 1'b0, 1'b0},
    {1'b0, 8'h7F, 8'h01, 8'h80, 1'b0, 1'b1},
    {1'b0, 8'hFF, 8'h01, 8'h00, 1'b1, 1'b0},
    {1'b0, 8'h80, 8'h80, 8'h00, 1'b1, 1'b1},
    {1'b1, 8'h05, 8'h03, 8'h02, 1'b1, 1'b0},
    {1'b1, 8'h03, 8'h05, 8'hFE, 1'b0, 1'b0},
    {1'b1, 8'h80, 8'h01, 8'h7F, 1'b1, 1'b1},
    {1'b1, 8'h7F, 8'hFF, 8'h80, 1'b0, 1'b1},
    {1'b1, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0}
  };

  logic seen [0:4095];

  always @(posedge clk) begin
    if (rst) cycles <= 0;
    else cycles <= cycles + 1;
    if (!done && cycles > 150000) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    sx = '0; sy = '0; sanc = '0; smode = 0; sacin = 0; saovf = 0;
    wx = '0; wy = '0; wanc = '0; wmode = 0; wacin = 0; waovf = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);

    // All-zero inputs give all-zero outputs (idle state).
    check("R1 idle result", int'(wres), 0);
    check("R3 idle carry", int'(wcout), 0);
    check("R4 idle ovf", int'(wovf), 0);

    // Table walk on the wide instance.
    for (int i = 0; i < NVEC; i++) begin
      {wmode, wx, wy} = VEC[i][26:10];
      #2;
      check(VEC[i][26] ? "R2 table result" : "R1 table result",
            int'(wres), int'(VEC[i][9:2]));
      check("R3 table carry", int'(wcout), int'(VEC[i][1]));
      check("R4 table ovf", int'(wovf), int'(VEC[i][0]));
      check("R5 table mode copy", int'(wmf), int'(wmode));
      check("R7 table parity", int'(wpar), int'(wx ^ wy ^ {NW{wmode}}));
    end

    // R9: forced carry-in in add mode: 5 + 3 + 1 = 9.
    wmode = 0; wx = 8'h05; wy = 8'h03; wacin = 1; #2;
    check("R9 anc_cin add", int'(wres), 9);
    // R9: forced carry-in in subtract mode cancels the +1: 5 + ~3 = 0x101.
    wmode = 1; #2;
    check("R9 anc_cin sub", int'(wres), 1);
    wacin = 0;

    // R10: ancilla on overflow inverts the flag only.
    wmode = 0; wx = 8'h7F; wy = 8'h01; waovf = 1; #2;
    check("R10 inverted ovf", int'(wovf), 0);
    check("R10 result kept", int'(wres), 8'h80);
    check("R10 carry kept", int'(wcout), 0);
    wx = 8'h05; wy = 8'h03; #2;
    check("R10 inverted ovf clear case", int'(wovf), 1);
    waovf = 0;

    // Exhaustive operand sweep on the small instance.
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 8; a++) begin
        for (int b = 0; b < 8; b++) begin
          int sa, sb, sr, er, ec, eo;
          smode = m[0]; sx = a[2:0]; sy = b[2:0]; sanc = '0; sacin = 0; saovf = 0;
          #2;
          sa = (a >= 4) ? a - 8 : a;
          sb = (b >= 4) ? b - 8 : b;
          if (m == 0) begin
            er = (a + b) % 8; ec = (a + b >= 8) ? 1 : 0; sr = sa + sb;
            check("R1 sweep sum", int'(sres), er);
          end else begin
            er = (a - b + 8) % 8; ec = (a >= b) ? 1 : 0; sr = sa - sb;
            check("R2 sweep diff", int'(sres), er);
          end
          eo = (sr < -4 || sr > 3) ? 1 : 0;
          check("R3 sweep carry", int'(scout), ec);
          check("R4 sweep ovf", int'(sovf), eo);
          check("R5 sweep mode copy", int'(smf), m);
          check("R6 sweep x copy", int'(sxc), a);
          check("R7 sweep parity", int'(spar), (a ^ b ^ (m * 7)));
        end
      end
    end

    // R8: bijectivity over the whole 12-line input space.
    for (int k = 0; k < 4096; k++) seen[k] = 1'b0;
    for (int k = 0; k < 4096; k++) begin
      logic [11:0] iv;
      logic [11:0] ov;
      iv = k[11:0];
      {saovf, sacin, sanc, smode, sx, sy} = iv;
      #2;
      ov = {sovf, scout, smf, sres, sxc, spar};
      check("R8 distinct output", int'(seen[ov]), 0);
      seen[ov] = 1'b1;
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule